// File: doc/BRIEF.md
# Delayed Special Cycle Forwarder

This block sits in a bridge between a near bus and a far bus. It takes a configuration write that the bridge has already decoded as a request to broadcast a special cycle on the far bus. It carries out that request as a delayed transaction. The first attempt from the initiator is captured and told to retry, so the initiator is not held while the far-side cycle runs. The block then starts one special cycle on the far bus. On that bus nobody claims a special cycle, so the cycle always ends in a master abort, and the block treats that abort as the normal end of the cycle. When the initiator tries the same request again, the block accepts it with target ready. No abort status is ever passed back.

The controller has four states. ST_IDLE: no request is held. ST_ISSUE: the far-side start is driven for one cycle. ST_WAIT: the block waits for the far-side master abort. ST_DONE: the completion is held until the initiator comes back. The transitions are:
- IDLE to ISSUE on any attempt, which is captured and retried.
- ISSUE to WAIT unconditionally after one cycle.
- WAIT to DONE on a far-side master abort.
- DONE to IDLE on a matching attempt, which is accepted.

In every other case the state stays where it is. Any attempt that does not cause an acceptance gets retry.

Top module: `spc_fwd`

## Requirements
- R1: While reset is held and right after it, tgt_retry, tgt_trdy, tgt_disc and far_start are all 0.
- R2: An attempt that arrives in ST_IDLE gets tgt_retry for one cycle in the cycle after it is presented. That attempt's data is captured. In the same cycle as that retry, far_start goes high for exactly one cycle, with far_cmd equal to SPC_CMD (default 4'h1) and far_data equal to the captured data.
- R3: The address of an attempt has no effect. It does not change far_cmd or far_data, and it takes no part in matching a repeated attempt.
- R4: An attempt that arrives while the request is queued or executing (ST_ISSUE or ST_WAIT) gets tgt_retry, even if it matches, and it starts no further far cycle.
- R5: A far_mabort pulse in ST_WAIT completes the request. The initiator is never given an abort indication; its next matching attempt is accepted instead.
- R6: In ST_DONE, an attempt matches only when both its tgt_cmd and its tgt_data equal the captured values. A matching attempt gets tgt_trdy; any other attempt gets tgt_retry and leaves the completion in place.
- R7: When an accepted attempt has tgt_multi = 1 (more than one data transfer requested), tgt_disc is 1 in the same cycle as tgt_trdy. Otherwise tgt_disc is 0.
- R8: After an acceptance the completion is discarded. An identical attempt that follows is treated as a new request: it gets retry and starts a new far cycle.
- R9: A far_mabort pulse in ST_IDLE or ST_DONE has no effect.
- R10: tgt_retry and tgt_trdy are never both 1. Each response lasts one cycle and appears only in the cycle after an attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_req | input | 1 | One-cycle pulse: an attempt is presented |
| tgt_addr | input | ADDR_W | Attempt address (ignored) |
| tgt_cmd | input | CMD_W | Attempt bus command |
| tgt_data | input | DATA_W | Attempt write data (special cycle message) |
| tgt_multi | input | 1 | Attempt asks for more than one data transfer |
| tgt_retry | output | 1 | Attempt answered with retry |
| tgt_trdy | output | 1 | Attempt accepted |
| tgt_disc | output | 1 | Disconnect in the first data phase of the accepted attempt |
| far_start | output | 1 | One-cycle start of the far special cycle |
| far_cmd | output | CMD_W | Far bus command (special cycle) |
| far_data | output | DATA_W | Far data-phase message |
| far_mabort | input | 1 | Far cycle ended by master abort |

## Verification
Repeated attempts are tried with these patterns, and each one separates a different fault:
- the same command and data but a new address, which shows that the address is ignored;
- a changed data word only, or a changed command only, which shows that both fields are compared;
- an identical attempt made before the abort, which shows that the block does not accept early.

Spurious aborts in the idle and done states, and a second identical request after an acceptance, show whether the slot is freed and whether it reacts to a stray abort. A seeded random mix of attempts and aborts, some of which match, is then checked against a bench model of the four states.

// File: rtl/spc_pkg.sv
package spc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } spc_state_t;
endpackage

// File: rtl/spc_req_latch.sv
module spc_req_latch #(
    parameter int CMD_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] held_data,
    output logic              match
);
    logic [CMD_W-1:0] held_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cmd  <= '0;
            held_data <= '0;
        end else if (load) begin
            held_cmd  <= in_cmd;
            held_data <= in_data;
        end
    end

    // A repeat is recognised by command and message together
    assign match = (in_cmd == held_cmd) && (in_data == held_data);
endmodule

// File: rtl/spc_fsm.sv
module spc_fsm
    import spc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic multi,
    input  logic match,
    input  logic mabort,
    output logic load,
    output logic far_start,
    output logic retry,
    output logic trdy,
    output logic disc
);
    spc_state_t st, st_n;
    logic       retry_n, trdy_n, disc_n;

    // State and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            retry <= 1'b0;
            trdy  <= 1'b0;
            disc  <= 1'b0;
        end else begin
            st    <= st_n;
            retry <= retry_n;
            trdy  <= trdy_n;
            disc  <= disc_n;
        end
    end

    // Next state and responses
    always_comb begin
        st_n    = st;
        load    = 1'b0;
        retry_n = 1'b0;
        trdy_n  = 1'b0;
        disc_n  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req) begin
                    load    = 1'b1;
                    retry_n = 1'b1;
                    st_n    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                retry_n = req;
                st_n    = ST_WAIT;
            end
            ST_WAIT: begin
                retry_n = req;
                if (mabort) st_n = ST_DONE;
            end
            ST_DONE: begin
                if (req) begin
                    if (match) begin
                        trdy_n = 1'b1;
                        disc_n = multi;
                        st_n   = ST_IDLE;
                    end else begin
                        retry_n = 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign far_start = (st == ST_ISSUE);
endmodule

// File: rtl/spc_fwd.sv
module spc_fwd #(
    parameter int          ADDR_W  = 32,
    parameter int          CMD_W   = 4,
    parameter int          DATA_W  = 32,
    parameter logic [3:0]  SPC_CMD = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_req,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [CMD_W-1:0]  tgt_cmd,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic              tgt_multi,
    output logic              tgt_retry,
    output logic              tgt_trdy,
    output logic              tgt_disc,
    output logic              far_start,
    output logic [CMD_W-1:0]  far_cmd,
    output logic [DATA_W-1:0] far_data,
    input  logic              far_mabort
);
    logic load, match;
    logic addr_unused;

    // The address of a special cycle carries no meaning
    assign addr_unused = ^tgt_addr;

    spc_req_latch #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .in_cmd    (tgt_cmd),
        .in_data   (tgt_data),
        .held_data (far_data),
        .match     (match)
    );

    spc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (tgt_req),
        .multi     (tgt_multi),
        .match     (match),
        .mabort    (far_mabort),
        .load      (load),
        .far_start (far_start),
        .retry     (tgt_retry),
        .trdy      (tgt_trdy),
        .disc      (tgt_disc)
    );

    assign far_cmd = CMD_W'(SPC_CMD);
endmodule

// File: rtl/spc_fwd_checker.sv
module spc_fwd_checker (
    input logic clk,
    input logic rst_n,
    input logic tgt_req,
    input logic tgt_multi,
    input logic tgt_retry,
    input logic tgt_trdy,
    input logic tgt_disc,
    input logic far_start
);
    logic started;

    always_ff @(posedge clk) begin
        if (!rst_n)          started <= 1'b0;
        else if (far_start)  started <= 1'b1;
        else if (tgt_trdy)   started <= 1'b0;
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_retry && tgt_trdy));

    p_resp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_retry || tgt_trdy) |-> $past(tgt_req));

    p_disc_with_trdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_disc |-> (tgt_trdy && $past(tgt_multi)));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        far_start |=> !far_start);

    p_start_with_retry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        far_start |-> tgt_retry);

    p_trdy_after_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_trdy |-> started);
endmodule

bind spc_fwd spc_fwd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_req   (tgt_req),
    .tgt_multi (tgt_multi),
    .tgt_retry (tgt_retry),
    .tgt_trdy  (tgt_trdy),
    .tgt_disc  (tgt_disc),
    .far_start (far_start)
);

// File: tb/spc_fwd_bench.sv
`timescale 1ns/1ps
module spc_fwd_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_req = 1'b0;
    logic [31:0] tgt_addr = '0;
    logic [3:0]  tgt_cmd = '0;
    logic [31:0] tgt_data = '0;
    logic        tgt_multi = 1'b0;
    logic        tgt_retry, tgt_trdy, tgt_disc, far_start;
    logic [3:0]  far_cmd;
    logic [31:0] far_data;
    logic        far_mabort = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model: 0 idle, 1 busy, 2 done
    int          m_st = 0;
    logic [3:0]  m_cmd = '0;
    logic [31:0] m_data = '0;

    always #10 clk = ~clk;

    spc_fwd u_spc_fwd (
        .clk(clk), .rst_n(rst_n), .tgt_req(tgt_req), .tgt_addr(tgt_addr),
        .tgt_cmd(tgt_cmd), .tgt_data(tgt_data), .tgt_multi(tgt_multi),
        .tgt_retry(tgt_retry), .tgt_trdy(tgt_trdy), .tgt_disc(tgt_disc),
        .far_start(far_start), .far_cmd(far_cmd), .far_data(far_data),
        .far_mabort(far_mabort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_match(input logic [3:0] c, input logic [31:0] d);
        return (m_st == 2) && (c == m_cmd) && (d == m_data);
    endfunction

    task automatic attempt(input string tag, input logic [31:0] a, input logic [3:0] c,
                           input logic [31:0] d, input logic mu);
        bit e_trdy, e_start;
        e_trdy  = exp_match(c, d);
        e_start = (m_st == 0);
        @(negedge clk);
        tgt_req = 1'b1; tgt_addr = a; tgt_cmd = c; tgt_data = d; tgt_multi = mu;
        @(negedge clk);
        tgt_req = 1'b0; tgt_addr = $urandom; tgt_cmd = 4'($urandom); tgt_data = $urandom;
        chk({tag, " retry"}, 32'(tgt_retry), 32'(!e_trdy));
        chk({tag, " trdy"},  32'(tgt_trdy),  32'(e_trdy));
        chk({tag, " disc R7"}, 32'(tgt_disc), 32'(e_trdy && mu));
        chk({tag, " far_start"}, 32'(far_start), 32'(e_start));
        if (e_start) begin
            chk({tag, " far_cmd R2"},  32'(far_cmd), 32'h1);
            chk({tag, " far_data R2"}, far_data, d);
            m_st = 1; m_cmd = c; m_data = d;
            @(negedge clk);
            chk({tag, " start pulse R2"}, 32'(far_start), 32'd0);
        end else if (e_trdy) begin
            m_st = 0;
        end
    endtask

    task automatic abort_pulse(input string tag);
        @(negedge clk);
        far_mabort = 1'b1;
        @(negedge clk);
        far_mabort = 1'b0;
        chk({tag, " no response"}, 32'(tgt_retry | tgt_trdy | far_start), 32'd0);
        if (m_st == 1) m_st = 2;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk("R1 reset resp", 32'(tgt_retry | tgt_trdy | tgt_disc | far_start), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 32'(tgt_retry | tgt_trdy | tgt_disc | far_start), 32'd0);

        // Basic flow with address change on repeat
        attempt("R2 first", 32'h1000, 4'hB, 32'hCAFE0001, 1'b0);
        attempt("R4 same while waiting", 32'h1000, 4'hB, 32'hCAFE0001, 1'b0);
        abort_pulse("R5 abort");
        attempt("R6 data differs", 32'h1000, 4'hB, 32'hCAFE0002, 1'b0);
        attempt("R6 cmd differs", 32'h1000, 4'hA, 32'hCAFE0001, 1'b0);
        attempt("R3 new addr match", 32'h7777, 4'hB, 32'hCAFE0001, 1'b0);
        // Idle spurious abort, then a fresh request
        abort_pulse("R9 idle abort");
        attempt("R9 after idle abort", 32'h0, 4'hB, 32'h12345678, 1'b1);
        abort_pulse("R5 abort 2");
        abort_pulse("R9 done abort");
        attempt("R7 multi accept", 32'h4, 4'hB, 32'h12345678, 1'b1);
        attempt("R8 repeat after accept", 32'h4, 4'hB, 32'h12345678, 1'b0);
        abort_pulse("R5 abort 3");
        attempt("R8 accept", 32'h8, 4'hB, 32'h12345678, 1'b0);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 3) begin
                abort_pulse("R5 random abort");
            end else if (m_st == 2 && op == 0) begin
                attempt("R6 random match", $urandom, m_cmd, m_data, 1'($urandom));
            end else begin
                attempt("R10 random attempt", $urandom, 4'($urandom_range(0, 1) + 4'hA),
                        32'($urandom_range(0, 3)), 1'($urandom));
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule